// File: doc/BRIEF.md
# Flash Block Erase Sequencer

This block walks an on-chip flash array through its erase procedure without software timing loops. A single start strobe hands it a bitmask of erase blocks; for each selected block, lowest index first, it raises the software-write enable, selects the block, arms an external watchdog, steps through erase setup and a bounded erase pulse, backs out of erase mode in the prescribed edge order, and then checks every word of the block. Each check is a dummy write of all-ones to the word followed, after a short settle, by a 32-bit read. A word that still holds a zero bit sends the block back through another erase pulse, up to a fixed pulse budget.

Every wait is counted in clock cycles from a single shared down-counter. Each delay is ceil(microseconds × CLK_HZ / 10^6) cycles, so the minimum times hold at any clock frequency. The erase pulse length is the parameter ERASE_US, which must not exceed 5000 µs. A watchdog overflow input, or running out of erase pulses, drops every flash control line and leaves the fail flag set until the next start.

States: IDLE, SWE_ON (write enable settling), PICK (choose the next pending block), ARM (block select and watchdog enable), ESU_ON (erase setup), ERASE (pulse), E_OFF, ESU_OFF, WDT_CLR, EV_WAIT (verify entry), DWRITE, RD_WAIT, READ, RETRY (verify abandoned, back to setup) and EV_OFF (verify exit). Transitions: start leads IDLE to SWE_ON. A timer expiry advances through the chain SWE_ON→PICK→ARM→ESU_ON→ERASE→E_OFF→ESU_OFF→WDT_CLR→EV_WAIT→DWRITE→RD_WAIT→READ. In READ, a good word that is not the last one goes to DWRITE, and the last good word goes to EV_OFF. A bad word goes to RETRY→ESU_ON, or to IDLE with fail once the pulse budget is spent. EV_OFF leads to PICK while blocks remain, otherwise to IDLE with done. PICK with nothing pending leads to IDLE with done. Watchdog overflow in any state leads to IDLE with fail.

Top module: `flash_erase_seq`

## Requirements
- R1: After reset, busy, done, fail, swe, esu, erase_en, ev, wdt_en, wdt_clr, dw_stb, rd_stb and blk_sel are all low.
- R2: A start strobe while idle raises swe and busy on the next cycle and clears done and fail; blk_sel is first asserted no fewer than ceil(10 µs) cycles after swe rises.
- R3: erase_en only rises after esu has been high for at least ceil(200 µs) cycles, is only high while esu, swe and a block select are high, and each erase pulse lasts exactly ceil(ERASE_US) cycles.
- R4: esu falls no sooner than ceil(10 µs) cycles after erase_en falls; the one-cycle wdt_clr pulse comes no sooner than ceil(10 µs) cycles after esu falls, and ev rises only after it.
- R5: The first dummy write of a verify pass comes at least ceil(20 µs) cycles after ev rises and targets the block's first address; addresses then ascend by one up to the block's last address. Each dummy write carries data 32'hFFFF_FFFF while ev is high, and each read strobe is issued to the most recently written address at least ceil(2 µs) cycles after it.
- R6: A read word that is not 32'hFFFF_FFFF ends the verify pass; ev drops and the same block receives another erase pulse without being selected anew.
- R7: If the word still fails after MAX_TRY erase pulses on one block, the sequencer goes idle with fail high and done low. All flash control lines stay low, and fail holds until the next start.
- R8: blk_sel is one-hot or zero; blocks are processed in ascending index order; after a block verifies, ev drops and the next block is selected no sooner than ceil(5 µs) cycles later.
- R9: A start strobe while busy is ignored; the mask given with it has no effect on the blocks erased.
- R10: While wdt_expired is high, swe, esu, erase_en and ev are low in the same cycle; the sequencer is idle with fail high on the following cycle.
- R11: When every selected block has verified, the sequencer goes idle with done high, fail low and swe low; an empty mask completes the same way without any erase pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start strobe, sampled while idle |
| blk_mask | input | NUM_BLK | Blocks to erase, bit i = block i |
| blk_first | input | NUM_BLK*ADDR_W | First word address of each block, block i at bits [i*ADDR_W +: ADDR_W] |
| blk_last | input | NUM_BLK*ADDR_W | Last word address of each block, same packing |
| rd_data | input | 32 | Verify read word for addr, sampled during rd_stb |
| wdt_expired | input | 1 | Watchdog overflow |
| swe | output | 1 | Software write enable to the flash |
| esu | output | 1 | Erase setup |
| erase_en | output | 1 | Erase pulse |
| ev | output | 1 | Erase-verify mode |
| blk_sel | output | NUM_BLK | One-hot erase block select |
| wdt_en | output | 1 | Watchdog enable during erase |
| wdt_clr | output | 1 | One-cycle watchdog clear |
| dw_stb | output | 1 | Dummy write strobe |
| dw_data | output | 32 | Dummy write data, all ones |
| rd_stb | output | 1 | Verify read strobe |
| addr | output | ADDR_W | Word address for dummy write and read |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence completed |
| fail | output | 1 | Last sequence aborted |

## Verification
The assertions assume the flash answers a read in the same cycle as rd_stb. They also assume that blk_first is no greater than blk_last for every block, and that wdt_expired goes high only because of a real overflow, not as a level held through reset. The bench keeps to these assumptions. A behavioural array model answers reads combinationally from the number of erase pulses each block has received, and the block ranges are fixed and ascending. The watchdog input is raised only once, for one cycle, in the middle of an erase pulse. Start and the mask are driven on falling edges, and pulse lengths and gaps are measured in whole cycles on falling edges.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SWE_ON,
        ST_PICK,
        ST_ARM,
        ST_ESU_ON,
        ST_ERASE,
        ST_E_OFF,
        ST_ESU_OFF,
        ST_WDT_CLR,
        ST_EV_WAIT,
        ST_DWRITE,
        ST_RD_WAIT,
        ST_READ,
        ST_RETRY,
        ST_EV_OFF
    } seq_state_t;

    // cycles covering at least 'us' microseconds at 'hz', rounded up
    function automatic longint unsigned us_cycles(longint unsigned us, longint unsigned hz);
        return (us * hz + 64'd999_999) / 64'd1_000_000;
    endfunction

endpackage

// File: rtl/flash_seq_timer.sv
module flash_seq_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          zero
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/flash_blk_pick.sv
module flash_blk_pick #(
    parameter int NB = 4,
    parameter int IW = 2
) (
    input  logic [NB-1:0] pend,
    output logic          any,
    output logic [IW-1:0] idx
);
    // lowest pending index wins
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (pend[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/flash_blk_range.sv
module flash_blk_range #(
    parameter int NB = 4,
    parameter int AW = 16,
    parameter int IW = 2
) (
    input  logic [NB*AW-1:0] first_all,
    input  logic [NB*AW-1:0] last_all,
    input  logic [IW-1:0]    idx,
    output logic [AW-1:0]    first,
    output logic [AW-1:0]    last
);
    always_comb begin
        first = '0;
        last  = '0;
        for (int i = 0; i < NB; i++) begin
            if (idx == IW'(i)) begin
                first = first_all[i*AW +: AW];
                last  = last_all[i*AW +: AW];
            end
        end
    end
endmodule

// File: rtl/flash_erase_seq.sv
module flash_erase_seq
    import flash_seq_pkg::*;
#(
    parameter int NUM_BLK  = 4,
    parameter int ADDR_W   = 16,
    parameter int CLK_HZ   = 20_000_000,
    parameter int ERASE_US = 5000,
    parameter int MAX_TRY  = 60
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      start,
    input  logic [NUM_BLK-1:0]        blk_mask,
    input  logic [NUM_BLK*ADDR_W-1:0] blk_first,
    input  logic [NUM_BLK*ADDR_W-1:0] blk_last,
    input  logic [31:0]               rd_data,
    input  logic                      wdt_expired,
    output logic                      swe,
    output logic                      esu,
    output logic                      erase_en,
    output logic                      ev,
    output logic [NUM_BLK-1:0]        blk_sel,
    output logic                      wdt_en,
    output logic                      wdt_clr,
    output logic                      dw_stb,
    output logic [31:0]               dw_data,
    output logic                      rd_stb,
    output logic [ADDR_W-1:0]         addr,
    output logic                      busy,
    output logic                      done,
    output logic                      fail
);
    localparam longint unsigned HZ      = longint'(CLK_HZ);
    localparam longint unsigned C_SWE   = us_cycles(10, HZ);
    localparam longint unsigned C_ESU   = us_cycles(200, HZ);
    localparam longint unsigned C_ERASE = us_cycles(longint'(ERASE_US), HZ);
    localparam longint unsigned C_EOFF  = us_cycles(10, HZ);
    localparam longint unsigned C_WDT   = us_cycles(10, HZ);
    localparam longint unsigned C_EV    = us_cycles(20, HZ);
    localparam longint unsigned C_DW    = us_cycles(2, HZ);
    localparam longint unsigned C_EVOFF = us_cycles(5, HZ);
    localparam longint unsigned C_MAX   = (C_ERASE > C_ESU) ? C_ERASE : C_ESU;
    localparam int CW = $clog2(C_MAX + 1);
    localparam int IW = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;
    localparam int TW = $clog2(MAX_TRY + 1);

    localparam logic [CW-1:0] L_SWE   = CW'(C_SWE - 1);
    localparam logic [CW-1:0] L_ESU   = CW'(C_ESU - 1);
    localparam logic [CW-1:0] L_ERASE = CW'(C_ERASE - 1);
    localparam logic [CW-1:0] L_EOFF  = CW'(C_EOFF - 1);
    localparam logic [CW-1:0] L_WDT   = CW'(C_WDT - 1);
    localparam logic [CW-1:0] L_EV    = CW'(C_EV - 1);
    localparam logic [CW-1:0] L_DW    = CW'(C_DW - 1);
    localparam logic [CW-1:0] L_EVOFF = CW'(C_EVOFF - 1);

    seq_state_t          state_q, state_d;
    logic                tmr_ld, tmr_zero;
    logic [CW-1:0]       tmr_val;
    logic [NUM_BLK-1:0]  pend_q, cur_oh;
    logic [IW-1:0]       cur_idx_q, pick_idx, rng_idx;
    logic                pick_any, rest_any, sel_on_q, word_ok, at_last;
    logic [ADDR_W-1:0]   addr_q, rng_first, rng_last;
    logic [TW-1:0]       tries_q;
    logic                done_q, fail_q;

    flash_seq_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_ld), .load_val(tmr_val), .zero(tmr_zero)
    );

    flash_blk_pick #(.NB(NUM_BLK), .IW(IW)) u_pick (
        .pend(pend_q), .any(pick_any), .idx(pick_idx)
    );

    assign rng_idx = (state_q == ST_PICK) ? pick_idx : cur_idx_q;

    flash_blk_range #(.NB(NUM_BLK), .AW(ADDR_W), .IW(IW)) u_range (
        .first_all(blk_first), .last_all(blk_last), .idx(rng_idx),
        .first(rng_first), .last(rng_last)
    );

    assign cur_oh   = NUM_BLK'(1) << cur_idx_q;
    assign rest_any = |(pend_q & ~cur_oh);
    assign word_ok  = (rd_data == 32'hFFFF_FFFF);
    assign at_last  = (addr_q == rng_last);

    // next state
    always_comb begin
        state_d = state_q;
        tmr_ld  = 1'b0;
        tmr_val = '0;
        unique case (state_q)
            ST_IDLE:    if (start) begin state_d = ST_SWE_ON; tmr_ld = 1'b1; tmr_val = L_SWE; end
            ST_SWE_ON:  if (tmr_zero) state_d = ST_PICK;
            ST_PICK:    state_d = pick_any ? ST_ARM : ST_IDLE;
            ST_ARM:     begin state_d = ST_ESU_ON; tmr_ld = 1'b1; tmr_val = L_ESU; end
            ST_ESU_ON:  if (tmr_zero) begin state_d = ST_ERASE; tmr_ld = 1'b1; tmr_val = L_ERASE; end
            ST_ERASE:   if (tmr_zero) begin state_d = ST_E_OFF; tmr_ld = 1'b1; tmr_val = L_EOFF; end
            ST_E_OFF:   if (tmr_zero) begin state_d = ST_ESU_OFF; tmr_ld = 1'b1; tmr_val = L_WDT; end
            ST_ESU_OFF: if (tmr_zero) state_d = ST_WDT_CLR;
            ST_WDT_CLR: begin state_d = ST_EV_WAIT; tmr_ld = 1'b1; tmr_val = L_EV; end
            ST_EV_WAIT: if (tmr_zero) state_d = ST_DWRITE;
            ST_DWRITE:  begin state_d = ST_RD_WAIT; tmr_ld = 1'b1; tmr_val = L_DW; end
            ST_RD_WAIT: if (tmr_zero) state_d = ST_READ;
            ST_READ: begin
                if (word_ok) begin
                    if (at_last) begin state_d = ST_EV_OFF; tmr_ld = 1'b1; tmr_val = L_EVOFF; end
                    else state_d = ST_DWRITE;
                end else if (tries_q == TW'(MAX_TRY)) begin
                    state_d = ST_IDLE;
                end else begin
                    state_d = ST_RETRY; tmr_ld = 1'b1; tmr_val = L_EVOFF;
                end
            end
            ST_RETRY:   if (tmr_zero) begin state_d = ST_ESU_ON; tmr_ld = 1'b1; tmr_val = L_ESU; end
            ST_EV_OFF:  if (tmr_zero) state_d = rest_any ? ST_PICK : ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
        if (state_q != ST_IDLE && wdt_expired) begin
            state_d = ST_IDLE;
            tmr_ld  = 1'b0;
        end
    end

    // state register and per-block bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            pend_q    <= '0;
            cur_idx_q <= '0;
            sel_on_q  <= 1'b0;
            addr_q    <= '0;
            tries_q   <= '0;
            done_q    <= 1'b0;
            fail_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                pend_q <= blk_mask;
                done_q <= 1'b0;
                fail_q <= 1'b0;
            end
            if (state_q == ST_PICK) begin
                if (pick_any) begin
                    cur_idx_q <= pick_idx;
                    sel_on_q  <= 1'b1;
                    addr_q    <= rng_first;
                    tries_q   <= '0;
                end else begin
                    done_q <= 1'b1;
                end
            end
            if (state_q == ST_ESU_ON && tmr_zero)
                tries_q <= tries_q + 1'b1;
            if (state_q == ST_READ && word_ok && !at_last)
                addr_q <= addr_q + 1'b1;
            if (state_q == ST_READ && !word_ok && tries_q == TW'(MAX_TRY)) begin
                fail_q   <= 1'b1;
                sel_on_q <= 1'b0;
            end
            if (state_q == ST_RETRY)
                addr_q <= rng_first;
            if (state_q == ST_EV_OFF && tmr_zero) begin
                pend_q[cur_idx_q] <= 1'b0;
                sel_on_q          <= 1'b0;
                if (!rest_any) done_q <= 1'b1;
            end
            if (state_q != ST_IDLE && wdt_expired) begin
                fail_q   <= 1'b1;
                sel_on_q <= 1'b0;
            end
        end
    end

    // outputs
    always_comb begin
        swe = 1'b0; esu = 1'b0; erase_en = 1'b0; ev = 1'b0;
        wdt_en = 1'b0; wdt_clr = 1'b0; dw_stb = 1'b0; rd_stb = 1'b0;
        unique case (state_q)
            ST_IDLE:    ;
            ST_SWE_ON, ST_PICK, ST_RETRY, ST_EV_OFF: swe = 1'b1;
            ST_ARM:     begin swe = 1'b1; wdt_en = 1'b1; end
            ST_ESU_ON:  begin swe = 1'b1; wdt_en = 1'b1; esu = 1'b1; end
            ST_ERASE:   begin swe = 1'b1; wdt_en = 1'b1; esu = 1'b1; erase_en = 1'b1; end
            ST_E_OFF:   begin swe = 1'b1; wdt_en = 1'b1; esu = 1'b1; end
            ST_ESU_OFF: begin swe = 1'b1; wdt_en = 1'b1; end
            ST_WDT_CLR: begin swe = 1'b1; wdt_clr = 1'b1; end
            ST_EV_WAIT, ST_RD_WAIT: begin swe = 1'b1; ev = 1'b1; end
            ST_DWRITE:  begin swe = 1'b1; ev = 1'b1; dw_stb = 1'b1; end
            ST_READ:    begin swe = 1'b1; ev = 1'b1; rd_stb = 1'b1; end
            default:    ;
        endcase
        blk_sel = sel_on_q ? cur_oh : '0;
        if (wdt_expired) begin
            swe = 1'b0; esu = 1'b0; erase_en = 1'b0; ev = 1'b0; wdt_en = 1'b0;
            wdt_clr = 1'b0; dw_stb = 1'b0; rd_stb = 1'b0; blk_sel = '0;
        end
    end

    assign dw_data = 32'hFFFF_FFFF;
    assign addr    = addr_q;
    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign fail    = fail_q;

    // pulse length tracker for the erase cap check
    logic [CW:0] e_run_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        e_run_q <= '0;
        else if (erase_en) e_run_q <= e_run_q + 1'b1;
        else               e_run_q <= '0;
    end

    // R3
    e_guarded_chk: assert property (@(posedge clk) disable iff (!rst_n)
        erase_en |-> (esu && swe && blk_sel != '0));
    // R3
    e_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        e_run_q <= (CW+1)'(C_ERASE));
    // R4
    esu_after_e_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(esu) |-> (!erase_en && $past(!erase_en)));
    // R5
    rd_in_verify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> (ev && !dw_stb && !esu));
    // R7
    fail_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (!swe && !esu && !erase_en && !ev && blk_sel == '0));
    // R10
    wdt_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_expired |-> (!swe && !esu && !erase_en && !ev));
    // R10
    wdt_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wdt_expired) |=> (fail && !busy));
    // R8
    sel_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(blk_sel));
    // R2
    sel_needs_swe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_sel != '0) |-> swe);
endmodule

// File: tb/flash_erase_seq_tb.sv
module flash_erase_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 4;
    localparam int AW = 8;
    localparam int ERASE_US = 20;
    localparam int MAX_TRY = 60;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [NB-1:0] blk_mask = '0;
    logic [NB*AW-1:0] blk_first = {8'd12, 8'd8, 8'd4, 8'd0};
    logic [NB*AW-1:0] blk_last  = {8'd15, 8'd11, 8'd7, 8'd3};
    logic [31:0] rd_data;
    logic wdt_expired = 1'b0;
    logic swe, esu, erase_en, ev, wdt_en, wdt_clr, dw_stb, rd_stb, busy, done, fail;
    logic [NB-1:0] blk_sel;
    logic [31:0] dw_data;
    logic [AW-1:0] addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_erase_seq #(.NUM_BLK(NB), .ADDR_W(AW), .CLK_HZ(1_000_000),
                      .ERASE_US(ERASE_US), .MAX_TRY(MAX_TRY)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_mask(blk_mask),
        .blk_first(blk_first), .blk_last(blk_last), .rd_data(rd_data),
        .wdt_expired(wdt_expired), .swe(swe), .esu(esu), .erase_en(erase_en),
        .ev(ev), .blk_sel(blk_sel), .wdt_en(wdt_en), .wdt_clr(wdt_clr),
        .dw_stb(dw_stb), .dw_data(dw_data), .rd_stb(rd_stb), .addr(addr),
        .busy(busy), .done(done), .fail(fail)
    );

    int n_chk = 0, n_bad = 0;
    int need [NB];
    int got  [NB];
    int order [16];
    int order_n = 0;
    int reads = 0;
    bit kill_test = 0;

    // behavioural array: a block reads erased once it has had enough pulses
    always_comb begin
        if (got[addr[3:2]] >= need[addr[3:2]]) rd_data = 32'hFFFF_FFFF;
        else                                   rd_data = 32'hFFFF_7FFF;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int oh2i(input logic [NB-1:0] v);
        int r = -1;
        for (int i = 0; i < NB; i++) if (v[i]) r = i;
        return r;
    endfunction

    // edge-timing monitor, sampled on falling edges
    int cyc = 0, t_swe = 0, t_esu = 0, t_e = 0, t_ef = 0, t_esuf = 0;
    int t_ev = 0, t_evf = 0, t_dw = 0, e_blk = 0, cur_blk = 0;
    logic [AW-1:0] dw_addr = '0;
    bit first_sel = 0, first_dw = 0;
    logic p_swe = 0, p_esu = 0, p_e = 0, p_ev = 0, p_sel = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            if (swe && !p_swe) begin t_swe = cyc; first_sel = 1; end
            if ((blk_sel != '0) && !p_sel) begin
                cur_blk = oh2i(blk_sel);
                if (first_sel) chk(cyc - t_swe >= 10, "R2", "swe to block select gap", cyc - t_swe, 10);
                else           chk(cyc - t_evf >= 5, "R8", "ev fall to next select gap", cyc - t_evf, 5);
                first_sel = 0;
                if (order_n < 16) order[order_n] = cur_blk;
                order_n++;
            end
            if (esu && !p_esu) t_esu = cyc;
            if (erase_en && !p_e) begin
                chk(cyc - t_esu >= 200, "R3", "esu to erase gap", cyc - t_esu, 200);
                t_e = cyc; e_blk = oh2i(blk_sel);
            end
            if (!erase_en && p_e) begin
                if (e_blk >= 0) got[e_blk]++;
                if (!kill_test) chk(cyc - t_e == ERASE_US, "R3", "erase pulse width", cyc - t_e, ERASE_US);
                t_ef = cyc;
            end
            if (!esu && p_esu) begin
                if (!kill_test) chk(cyc - t_ef >= 10, "R4", "erase fall to esu fall", cyc - t_ef, 10);
                t_esuf = cyc;
            end
            if (wdt_clr) chk(cyc - t_esuf >= 10, "R4", "esu fall to watchdog clear", cyc - t_esuf, 10);
            if (ev && !p_ev) begin
                chk(!esu && !erase_en, "R4", "ev rise with erase lines low", 1, 0);
                t_ev = cyc; first_dw = 1;
            end
            if (!ev && p_ev) t_evf = cyc;
            if (dw_stb) begin
                chk(dw_data == 32'hFFFF_FFFF && ev, "R5", "dummy write data", longint'(dw_data), 32'hFFFF_FFFF);
                if (first_dw) begin
                    chk(cyc - t_ev >= 20, "R5", "ev to first dummy write", cyc - t_ev, 20);
                    chk(int'(addr) == cur_blk * 4, "R5", "first verify address", addr, cur_blk * 4);
                end else begin
                    chk(addr == dw_addr + 1'b1, "R5", "ascending verify address", addr, dw_addr + 1);
                end
                first_dw = 0; t_dw = cyc; dw_addr = addr;
            end
            if (rd_stb) begin
                chk(addr == dw_addr, "R5", "read address matches dummy write", addr, dw_addr);
                chk(cyc - t_dw >= 2, "R5", "dummy write to read gap", cyc - t_dw, 2);
                reads++;
            end
        end
        p_swe = swe; p_esu = esu; p_e = erase_en; p_ev = ev; p_sel = (blk_sel != '0);
    end

    task automatic clear_model();
        for (int i = 0; i < NB; i++) begin got[i] = 0; need[i] = 1; end
        order_n = 0; reads = 0;
    endtask

    task automatic do_start(input logic [NB-1:0] m);
        @(negedge clk); start = 1'b1; blk_mask = m;
        @(negedge clk); start = 1'b0; blk_mask = '0;
    endtask

    task automatic wait_idle(input string req);
        int n = 0;
        while (busy && n < 60000) begin @(negedge clk); n++; end
        chk(!busy, req, "sequence finished in time", busy, 0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk(!busy && !done && !fail, "R1", "status after reset", {busy, done, fail}, 0);
        chk({swe, esu, erase_en, ev, wdt_en, wdt_clr, dw_stb, rd_stb} == '0 && blk_sel == '0,
            "R1", "controls after reset", {swe, esu, erase_en, ev}, 0);
    endtask

    task automatic t_single();
        clear_model();
        do_start(4'b0001);
        chk(swe && busy, "R2", "swe and busy after start", {swe, busy}, 3);
        wait_idle("R11");
        chk(done && !fail && !swe, "R11", "done after one block", {done, fail, swe}, 4);
        chk(got[0] == 1, "R3", "pulses on block 0", got[0], 1);
        chk(reads == 4, "R5", "words read in block 0", reads, 4);
    endtask

    task automatic t_multi();
        clear_model();
        need[3] = 3;
        do_start(4'b1010);
        wait_idle("R11");
        chk(done && !fail, "R11", "done after two blocks", {done, fail}, 2);
        chk(order_n == 2, "R6", "block selections", order_n, 2);
        chk(order[0] == 1 && order[1] == 3, "R8", "ascending block order", order[0] * 10 + order[1], 13);
        chk(got[3] == 3, "R6", "retry pulses on block 3", got[3], 3);
        chk(got[1] == 1 && got[0] == 0 && got[2] == 0, "R11", "unselected blocks untouched", got[0] + got[2], 0);
    endtask

    task automatic t_empty();
        clear_model();
        do_start(4'b0000);
        wait_idle("R11");
        chk(done && !fail, "R11", "empty mask completes", {done, fail}, 2);
        chk(got[0] + got[1] + got[2] + got[3] == 0, "R11", "no pulses on empty mask",
            got[0] + got[1] + got[2] + got[3], 0);
    endtask

    task automatic t_ignore();
        clear_model();
        do_start(4'b0001);
        repeat (50) @(negedge clk);
        do_start(4'b1110);
        wait_idle("R9");
        chk(got[1] + got[2] + got[3] == 0, "R9", "start while busy ignored", got[1] + got[2] + got[3], 0);
        chk(order_n == 1 && done, "R9", "only first request served", order_n, 1);
    endtask

    task automatic t_retry_limit();
        clear_model();
        need[0] = 1000;
        do_start(4'b0001);
        wait_idle("R7");
        chk(fail && !done, "R7", "fail after pulse budget", {fail, done}, 2);
        chk(got[0] == MAX_TRY, "R7", "erase pulses before fail", got[0], MAX_TRY);
        repeat (30) @(negedge clk);
        chk(fail && !swe && !esu && !ev && blk_sel == '0, "R7", "fail held with controls low", {fail, swe}, 2);
        clear_model();
        do_start(4'b0001);
        chk(!fail && busy, "R7", "fail cleared on next start", fail, 0);
        wait_idle("R7");
        chk(done && !fail, "R7", "clean run after fail", {done, fail}, 2);
    endtask

    task automatic t_wdt();
        int n = 0;
        clear_model();
        do_start(4'b0100);
        while (!erase_en && n < 2000) begin @(negedge clk); n++; end
        kill_test = 1;
        wdt_expired = 1'b1;
        #1;
        chk(!swe && !esu && !erase_en && !ev, "R10", "controls dropped same cycle", {swe, esu, erase_en, ev}, 0);
        @(negedge clk);
        chk(fail && !busy, "R10", "fail after watchdog", {fail, busy}, 2);
        wdt_expired = 1'b0;
        @(negedge clk);
        chk(!swe && fail, "R10", "stays down after watchdog", {swe, fail}, 1);
        kill_test = 0;
    endtask

    initial begin
        repeat (150000) @(negedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual 1 expected 0");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        clear_model();
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_multi();
        t_empty();
        t_ignore();
        t_retry_limit();
        t_wdt();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule